// File: doc/BRIEF.md
# Data Address Translation Checker

This block sits between a load/store unit and a translation lookaside buffer. It takes one virtual data address per request, together with the access direction, the privilege level and three control bits. The control bits are translation enable, single-virtual mode and a user-mode store-queue block. From these it decides whether the address bypasses translation, raises an address error, or needs a TLB lookup.

When a lookup is needed, the block issues it on a request/response interface and waits for the TLB's answer. It then turns that answer into either a physical address or a single exception code. A multi-hit is reported on a separate reset-class strobe. On every TLB-related fault it loads a fault-address register with the full virtual address and a page-number register with the virtual page bits.

The TLB storage and its matching logic are outside this block. The TLB returns a hit flag, a multi-hit flag, the page frame, a 2-bit page size code and the entry's user, writable and dirty bits.

Top module: `data_addr_xlate`

## Requirements
- R1: A privileged access to an address whose top three bits are 111 (0xE0000000 and up) passes through unchanged, without a lookup, whatever translation enable says.
- R2: A privileged access in 0x80000000..0xBFFFFFFF passes through with the address ANDed with 0x1FFFFFFF, without a lookup.
- R3: A user access with bit 31 set raises an address error: exception code 1 for a read, 2 for a write, with physical address 0. The one exception is 0xE0000000..0xE3FFFFFF, which passes through unchanged when the store-queue block bit is 0.
- R4: With translation disabled, a user access below 0x80000000 and a privileged access below 0x80000000 or in 0xC0000000..0xDFFFFFFF both pass through with the address ANDed with 0x1FFFFFFF.
- R5: With translation enabled, an access below 0x80000000, or a privileged access in 0xC0000000..0xDFFFFFFF, raises `lk_req` in the request cycle. `lk_ignore_asid` is 1 only when single-virtual mode is set and the access is privileged. `req_ready` stays low until `tlb_rsp_valid`, and the result appears on the clock edge after the response.
- R6: For a clean translation, the physical address is (frame AND mask) OR (virtual address AND NOT mask). The mask is 0xFFFFFC00, 0xFFFFF000, 0xFFFF0000 or 0xFFF00000 for size codes 0, 1, 2 and 3.
- R7: Permission rules:
  - A user read needs the user bit.
  - A privileged read always passes.
  - A privileged write needs the writable bit.
  - A user write needs both the user and writable bits.
  - A violation gives code 5 for a read or 6 for a write.
- R8: A permitted write to an entry with the dirty bit clear gives code 7 (initial page write).
- R9: Faults are ranked miss, then multi-hit, then protection, then dirty. A miss (hit flag 0) gives code 3 for a read or 4 for a write. A multi-hit gives code 0 with `res_multihit` set. Any fault gives physical address 0.
- R10: On any miss, multi-hit, protection or dirty fault, `flt_vaddr` loads the virtual address and `flt_vpn` loads its bits 31:10. Address errors and successful accesses leave both registers unchanged.
- R11: After reset, `res_valid`, `res_exc`, `res_multihit`, `flt_vaddr` and `flt_vpn` are 0 and `req_ready` is 1.
- R12: A pass-through or address-error result is a one-cycle `res_valid` pulse on the edge after the request. A TLB response that arrives while no lookup is pending produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request (low while a lookup is pending) |
| req_vaddr | input | ADDR_W | Virtual data address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| cfg_xlate_en | input | 1 | Address translation enable |
| cfg_single_virt | input | 1 | Single-virtual mode |
| cfg_sq_user_block | input | 1 | Blocks user access to the store-queue window |
| lk_req | output | 1 | TLB lookup request |
| lk_vaddr | output | ADDR_W | Address to look up |
| lk_ignore_asid | output | 1 | Lookup ignores the address-space identifier |
| tlb_rsp_valid | input | 1 | TLB answer present |
| tlb_hit | input | 1 | At least one entry matched |
| tlb_multi | input | 1 | More than one entry matched |
| tlb_ppn | input | ADDR_W | Page frame of the matched entry |
| tlb_size | input | 2 | Page size code |
| tlb_user | input | 1 | Entry user-accessible bit |
| tlb_wr | input | 1 | Entry writable bit |
| tlb_dirty | input | 1 | Entry dirty bit |
| res_valid | output | 1 | Result pulse |
| res_paddr | output | ADDR_W | Physical address (0 on a fault) |
| res_exc | output | 3 | Exception code (0 none, 1..7 as in the requirements) |
| res_multihit | output | 1 | Multi-hit, reset-class event |
| flt_vaddr | output | ADDR_W | Fault virtual address register |
| flt_vpn | output | ADDR_W-PAGE_LSB | Fault page-number register |

## Verification
The bench builds the block with its defaults: ADDR_W 32, EXT_W 29, PAGE_LSB 10. With these values the region boundaries, the 29-bit pass-through mask and all four page-size masks sit at the addresses the requirements name. The vector table crosses each region with each privilege level, direction and control setting, and plays a TLB that answers two cycles after a lookup. This exercises every fault code, the multi-hit strobe, and the rank of each fault against the next one down. It also checks that the fault registers stay unchanged after address errors and clean translations.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    typedef enum logic [2:0] {
        XC_NONE     = 3'd0,
        XC_RD_ADDR  = 3'd1,
        XC_WR_ADDR  = 3'd2,
        XC_RD_MISS  = 3'd3,
        XC_WR_MISS  = 3'd4,
        XC_RD_PROT  = 3'd5,
        XC_WR_PROT  = 3'd6,
        XC_INIT_WR  = 3'd7
    } xc_e;

    typedef enum logic [1:0] {
        RT_XLATE    = 2'd0,
        RT_PASS_RAW = 2'd1,
        RT_PASS_EXT = 2'd2,
        RT_ERROR    = 2'd3
    } route_e;

    typedef struct packed {
        logic is_write;
        logic is_priv;
    } acc_t;

    typedef struct packed {
        logic hit;
        logic multi;
        logic user;
        logic wr;
        logic dirty;
    } tlb_flags_t;

    // extra page-number bits masked off beyond the smallest page, per size code
    function automatic int unsigned page_shift(input logic [1:0] sz);
        case (sz)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 6;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/dxl_region_dec.sv
module dxl_region_dec
    import dxl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  acc_t              acc,
    input  logic              xlate_en,
    input  logic              single_virt,
    input  logic              sq_user_block,
    output route_e            route,
    output logic              ignore_asid
);
    localparam logic [2:0] TOP_P3 = 3'b110;
    localparam logic [2:0] TOP_P4 = 3'b111;
    localparam logic [5:0] SQ_TOP = 6'b111000;

    logic [2:0] top3;
    logic [5:0] top6;

    assign top3 = vaddr[ADDR_W-1 -: 3];
    assign top6 = vaddr[ADDR_W-1 -: 6];

    always_comb begin
        if (!vaddr[ADDR_W-1]) begin
            route = xlate_en ? RT_XLATE : RT_PASS_EXT;
        end else if (acc.is_priv) begin
            if (top3 == TOP_P4)
                route = RT_PASS_RAW;
            else if (top3 == TOP_P3)
                route = xlate_en ? RT_XLATE : RT_PASS_EXT;
            else
                route = RT_PASS_EXT;
        end else if (top6 == SQ_TOP && !sq_user_block) begin
            route = RT_PASS_RAW;
        end else begin
            route = RT_ERROR;
        end
    end

    assign ignore_asid = single_virt & acc.is_priv;

endmodule

// File: rtl/dxl_perm_chk.sv
module dxl_perm_chk
    import dxl_pkg::*;
(
    input  tlb_flags_t fl,
    input  acc_t       acc,
    output xc_e        exc,
    output logic       multihit,
    output logic       tlb_fault
);
    logic allowed;

    always_comb begin
        if (acc.is_write)
            allowed = acc.is_priv ? fl.wr : (fl.user & fl.wr);
        else
            allowed = acc.is_priv | fl.user;
    end

    // ranked: miss, multi-hit, protection, dirty
    always_comb begin
        exc       = XC_NONE;
        multihit  = 1'b0;
        tlb_fault = 1'b1;
        if (!fl.hit)
            exc = acc.is_write ? XC_WR_MISS : XC_RD_MISS;
        else if (fl.multi)
            multihit = 1'b1;
        else if (!allowed)
            exc = acc.is_write ? XC_WR_PROT : XC_RD_PROT;
        else if (acc.is_write && !fl.dirty)
            exc = XC_INIT_WR;
        else
            tlb_fault = 1'b0;
    end

endmodule

// File: rtl/dxl_fault_regs.sv
module dxl_fault_regs #(
    parameter int ADDR_W   = 32,
    parameter int PAGE_LSB = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          vaddr,
    output logic [ADDR_W-1:0]          flt_vaddr,
    output logic [ADDR_W-PAGE_LSB-1:0] flt_vpn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flt_vaddr <= '0;
            flt_vpn   <= '0;
        end else if (load) begin
            flt_vaddr <= vaddr;
            flt_vpn   <= vaddr[ADDR_W-1:PAGE_LSB];
        end
    end
endmodule

// File: rtl/data_addr_xlate.sv
module data_addr_xlate
    import dxl_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int EXT_W    = 29,
    parameter int PAGE_LSB = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_vaddr,
    input  logic                       req_write,
    input  logic                       req_priv,
    input  logic                       cfg_xlate_en,
    input  logic                       cfg_single_virt,
    input  logic                       cfg_sq_user_block,
    output logic                       lk_req,
    output logic [ADDR_W-1:0]          lk_vaddr,
    output logic                       lk_ignore_asid,
    input  logic                       tlb_rsp_valid,
    input  logic                       tlb_hit,
    input  logic                       tlb_multi,
    input  logic [ADDR_W-1:0]          tlb_ppn,
    input  logic [1:0]                 tlb_size,
    input  logic                       tlb_user,
    input  logic                       tlb_wr,
    input  logic                       tlb_dirty,
    output logic                       res_valid,
    output logic [ADDR_W-1:0]          res_paddr,
    output logic [2:0]                 res_exc,
    output logic                       res_multihit,
    output logic [ADDR_W-1:0]          flt_vaddr,
    output logic [ADDR_W-PAGE_LSB-1:0] flt_vpn
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] EXT_MASK = ALL_ONES >> (ADDR_W - EXT_W);

    acc_t              in_acc, hold_acc;
    logic [ADDR_W-1:0] hold_va;
    logic              busy_q;
    route_e            route;
    logic              ign_asid;
    logic              take, finish;

    logic [ADDR_W-1:0] byp_pa;
    xc_e               byp_exc;

    tlb_flags_t        tflags;
    xc_e               chk_exc;
    logic              chk_multi, chk_fault;
    logic [ADDR_W-1:0] pg_mask, xl_pa;

    assign in_acc = '{is_write: req_write, is_priv: req_priv};

    dxl_region_dec #(.ADDR_W(ADDR_W)) u_dec (
        .vaddr         (req_vaddr),
        .acc           (in_acc),
        .xlate_en      (cfg_xlate_en),
        .single_virt   (cfg_single_virt),
        .sq_user_block (cfg_sq_user_block),
        .route         (route),
        .ignore_asid   (ign_asid)
    );

    assign req_ready      = !busy_q;
    assign take           = req_valid && !busy_q;
    assign lk_req         = take && (route == RT_XLATE);
    assign lk_vaddr       = req_vaddr;
    assign lk_ignore_asid = ign_asid;
    assign finish         = busy_q && tlb_rsp_valid;

    always_comb begin
        byp_pa  = '0;
        byp_exc = XC_NONE;
        case (route)
            RT_PASS_RAW: byp_pa = req_vaddr;
            RT_PASS_EXT: byp_pa = req_vaddr & EXT_MASK;
            RT_ERROR:    byp_exc = req_write ? XC_WR_ADDR : XC_RD_ADDR;
            default:     byp_pa = '0;
        endcase
    end

    assign tflags = '{hit: tlb_hit, multi: tlb_multi, user: tlb_user,
                      wr: tlb_wr, dirty: tlb_dirty};

    dxl_perm_chk u_perm (
        .fl        (tflags),
        .acc       (hold_acc),
        .exc       (chk_exc),
        .multihit  (chk_multi),
        .tlb_fault (chk_fault)
    );

    assign pg_mask = ALL_ONES << (PAGE_LSB + page_shift(tlb_size));
    assign xl_pa   = (tlb_ppn & pg_mask) | (hold_va & ~pg_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q       <= 1'b0;
            hold_va      <= '0;
            hold_acc     <= '0;
            res_valid    <= 1'b0;
            res_paddr    <= '0;
            res_exc      <= XC_NONE;
            res_multihit <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (take && route != RT_XLATE) begin
                res_valid    <= 1'b1;
                res_paddr    <= byp_pa;
                res_exc      <= byp_exc;
                res_multihit <= 1'b0;
            end
            if (lk_req) begin
                busy_q   <= 1'b1;
                hold_va  <= req_vaddr;
                hold_acc <= in_acc;
            end
            if (finish) begin
                busy_q       <= 1'b0;
                res_valid    <= 1'b1;
                res_paddr    <= chk_fault ? '0 : xl_pa;
                res_exc      <= chk_exc;
                res_multihit <= chk_multi;
            end
        end
    end

    dxl_fault_regs #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) u_flt (
        .clk       (clk),
        .rst       (rst),
        .load      (finish && chk_fault),
        .vaddr     (hold_va),
        .flt_vaddr (flt_vaddr),
        .flt_vpn   (flt_vpn)
    );

endmodule

// File: rtl/dxl_checker.sv
module dxl_checker
    import dxl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              lk_req,
    input logic              tlb_rsp_valid,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_paddr,
    input logic [2:0]        res_exc,
    input logic              res_multihit,
    input logic [ADDR_W-1:0] flt_vaddr
);
    p_multi_code_none_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_multihit |-> res_exc == XC_NONE);

    p_fault_pa_zero_r9: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_exc != XC_NONE || res_multihit) |-> res_paddr == '0);

    p_flt_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(flt_vaddr));

    p_addr_err_no_flt_r10: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_exc == XC_RD_ADDR || res_exc == XC_WR_ADDR) |-> $stable(flt_vaddr));

    p_lookup_when_ready_r5: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> req_ready && req_valid);

    p_busy_after_lookup_r5: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> !req_ready);

    p_result_after_rsp_r5: assert property (@(posedge clk) disable iff (rst)
        !req_ready && tlb_rsp_valid |=> res_valid && req_ready);

    p_bypass_latency_r12: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !lk_req |=> res_valid);

    p_no_spurious_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req_valid && req_ready && !lk_req)
                   || $past(!req_ready && tlb_rsp_valid));
endmodule

bind data_addr_xlate dxl_checker #(.ADDR_W(ADDR_W)) i_dxl_checker (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .lk_req        (lk_req),
    .tlb_rsp_valid (tlb_rsp_valid),
    .res_valid     (res_valid),
    .res_paddr     (res_paddr),
    .res_exc       (res_exc),
    .res_multihit  (res_multihit),
    .flt_vaddr     (flt_vaddr)
);

// File: tb/test_data_addr_xlate.sv
`timescale 1ns/1ps
module test_data_addr_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_priv = 1'b0;
    logic        cfg_xlate_en = 1'b0, cfg_single_virt = 1'b0, cfg_sq_user_block = 1'b0;
    logic        lk_req, lk_ignore_asid;
    logic [31:0] lk_vaddr;
    logic        tlb_rsp_valid = 1'b0, tlb_hit = 1'b0, tlb_multi = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [1:0]  tlb_size = '0;
    logic        tlb_user = 1'b0, tlb_wr = 1'b0, tlb_dirty = 1'b0;
    logic        res_valid, res_multihit;
    logic [31:0] res_paddr;
    logic [2:0]  res_exc;
    logic [31:0] flt_vaddr;
    logic [21:0] flt_vpn;

    always #2.5 clk = ~clk;

    data_addr_xlate i_data_addr_xlate (.*);

    typedef struct packed {
        logic [31:0] va;
        logic        wr, pv, xen, sv, sqb;
        logic        hit, mul;
        logic [31:0] ppn;
        logic [1:0]  sz;
        logic        u, w, d;
        logic        lk, ign;
        logic [31:0] pa;
        logic [2:0]  exc;
        logic        mh, flt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        // R1 privileged top region, unchanged
        '{32'hE123_4567,'0,'1,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'hE123_4567,3'd0,'0,'0,4'd1},
        // R2 privileged 0xA... masked
        '{32'hA123_4567,'1,'1,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0123_4567,3'd0,'0,'0,4'd2},
        // R3 user high read error
        '{32'h8000_0000,'0,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0,3'd1,'0,'0,4'd3},
        // R3 user high write error
        '{32'hC000_1000,'1,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0,3'd2,'0,'0,4'd3},
        // R3 user store-queue window open
        '{32'hE200_0010,'0,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'hE200_0010,3'd0,'0,'0,4'd3},
        // R3 user store-queue window blocked
        '{32'hE200_0010,'1,'0,'1,'0,'1, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0,3'd2,'0,'0,4'd3},
        // R3 just past window
        '{32'hE400_0000,'0,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0,3'd1,'0,'0,4'd3},
        // R4 translation off, user low
        '{32'h7234_5678,'0,'0,'0,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h1234_5678,3'd0,'0,'0,4'd4},
        // R4 translation off, privileged 0xC...
        '{32'hC123_4567,'0,'1,'0,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0123_4567,3'd0,'0,'0,4'd4},
        // R6 4K page
        '{32'h1234_5678,'0,'1,'1,'0,'0, '1,'0, 32'h0ABC_D000,2'd1, '0,'0,'0, '1,'0, 32'h0ABC_D678,3'd0,'0,'0,4'd6},
        // R5 privileged 0xC... single-virtual, 1K page
        '{32'hC000_0ABC,'0,'1,'1,'1,'0, '1,'0, 32'h0555_5400,2'd0, '0,'0,'0, '1,'1, 32'h0555_56BC,3'd0,'0,'0,4'd5},
        // R5 user with single-virtual keeps ASID, 64K page
        '{32'h0000_1000,'0,'0,'1,'1,'0, '1,'0, 32'h0AB1_2345,2'd2, '1,'0,'0, '1,'0, 32'h0AB1_1000,3'd0,'0,'0,4'd5},
        // R6 1M page write
        '{32'h0012_3456,'1,'1,'1,'0,'0, '1,'0, 32'h0CDE_FFFF,2'd3, '0,'1,'1, '1,'0, 32'h0CD2_3456,3'd0,'0,'0,4'd6},
        // R9 read miss
        '{32'h0040_0000,'0,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '1,'0, 32'h0,3'd3,'0,'1,4'd9},
        // R9 write miss outranks multi flag
        '{32'h0080_0400,'1,'1,'1,'0,'0, '0,'1, 32'h0,2'd0, '0,'0,'0, '1,'0, 32'h0,3'd4,'0,'1,4'd9},
        // R9 multi-hit outranks protection
        '{32'h0100_0800,'0,'0,'1,'0,'0, '1,'1, 32'h0,2'd0, '0,'0,'0, '1,'0, 32'h0,3'd0,'1,'1,4'd9},
        // R7 user read no user bit
        '{32'h0200_0C00,'0,'0,'1,'0,'0, '1,'0, 32'h0,2'd0, '0,'1,'1, '1,'0, 32'h0,3'd5,'0,'1,4'd7},
        // R7 privileged write not writable, protection before dirty
        '{32'h0300_0000,'1,'1,'1,'0,'0, '1,'0, 32'h0,2'd0, '1,'0,'0, '1,'0, 32'h0,3'd6,'0,'1,4'd7},
        // R7 user write, user but not writable
        '{32'h0400_0000,'1,'0,'1,'0,'0, '1,'0, 32'h0,2'd0, '1,'0,'1, '1,'0, 32'h0,3'd6,'0,'1,4'd7},
        // R7 user write, writable but not user
        '{32'h0500_0000,'1,'0,'1,'0,'0, '1,'0, 32'h0,2'd0, '0,'1,'1, '1,'0, 32'h0,3'd6,'0,'1,4'd7},
        // R8 privileged write clean page
        '{32'h0600_0400,'1,'1,'1,'0,'0, '1,'0, 32'h0,2'd0, '0,'1,'0, '1,'0, 32'h0,3'd7,'0,'1,4'd8},
        // R8 user write clean page
        '{32'h0700_0800,'1,'0,'1,'0,'0, '1,'0, 32'h0,2'd0, '1,'1,'0, '1,'0, 32'h0,3'd7,'0,'1,4'd8},
        // R7 privileged read needs nothing
        '{32'h0800_0000,'0,'1,'1,'0,'0, '1,'0, 32'h0AAA_A000,2'd1, '0,'0,'0, '1,'0, 32'h0AAA_A000,3'd0,'0,'0,4'd7},
        // R10 address error leaves fault regs
        '{32'h8000_0000,'0,'0,'1,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0,3'd1,'0,'0,4'd10},
        // R10 clean write leaves fault regs
        '{32'h0000_0400,'1,'1,'1,'0,'0, '1,'0, 32'h0100_0000,2'd0, '0,'1,'1, '1,'0, 32'h0100_0000,3'd0,'0,'0,4'd10},
        // R4 privileged low with translation off
        '{32'h0000_0010,'0,'1,'0,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0, 32'h0000_0010,3'd0,'0,'0,4'd4}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_fva = '0;

    task automatic chk(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v.va; req_write = v.wr; req_priv = v.pv;
        cfg_xlate_en = v.xen; cfg_single_virt = v.sv; cfg_sq_user_block = v.sqb;
        #0.5;
        chk(lk_req == v.lk, int'(v.req), "lookup request", 32'(lk_req), 32'(v.lk));
        if (v.lk) begin
            chk(lk_ignore_asid == v.ign, 5, "ignore asid", 32'(lk_ignore_asid), 32'(v.ign));
            chk(lk_vaddr == v.va, 5, "lookup address", lk_vaddr, v.va);
            @(negedge clk);
            req_valid = 1'b0;
            chk(req_ready == 1'b0, 5, "ready while pending", 32'(req_ready), 32'd0);
            @(negedge clk);
            chk(res_valid == 1'b0, 5, "no result before response", 32'(res_valid), 32'd0);
            tlb_rsp_valid = 1'b1; tlb_hit = v.hit; tlb_multi = v.mul; tlb_ppn = v.ppn;
            tlb_size = v.sz; tlb_user = v.u; tlb_wr = v.w; tlb_dirty = v.d;
            @(negedge clk);
            tlb_rsp_valid = 1'b0;
        end else begin
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (v.flt) exp_fva = v.va;
        chk(res_valid == 1'b1, int'(v.req), "result valid", 32'(res_valid), 32'd1);
        chk(res_paddr == v.pa, int'(v.req), "physical address", res_paddr, v.pa);
        chk(res_exc == v.exc, int'(v.req), "exception code", 32'(res_exc), 32'(v.exc));
        chk(res_multihit == v.mh, int'(v.req), "multi-hit", 32'(res_multihit), 32'(v.mh));
        chk(flt_vaddr == exp_fva, 10, "fault address", flt_vaddr, exp_fva);
        chk(flt_vpn == exp_fva[31:10], 10, "fault page", 32'(flt_vpn), 32'(exp_fva[31:10]));
        @(negedge clk);
        chk(res_valid == 1'b0, 12, "one-cycle result pulse", 32'(res_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(res_valid == 1'b0, 11, "reset res_valid", 32'(res_valid), 32'd0);
        chk(req_ready == 1'b1, 11, "reset req_ready", 32'(req_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        chk(res_exc == 3'd0, 11, "reset exception", 32'(res_exc), 32'd0);
        chk(res_multihit == 1'b0, 11, "reset multi-hit", 32'(res_multihit), 32'd0);
        chk(flt_vaddr == 32'd0, 11, "reset fault address", flt_vaddr, 32'd0);
        chk(flt_vpn == 22'd0, 11, "reset fault page", 32'(flt_vpn), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R12 stray response while idle: no result, fault regs untouched
        tlb_rsp_valid = 1'b1; tlb_hit = 1'b0;
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
        chk(res_valid == 1'b0, 12, "idle response ignored", 32'(res_valid), 32'd0);
        chk(flt_vaddr == exp_fva, 12, "idle response fault regs", flt_vaddr, exp_fva);

        // R1 top region passes even with translation disabled
        run_vec('{32'hFF00_0004,'0,'1,'0,'0,'0, '0,'0, 32'h0,2'd0, '0,'0,'0, '0,'0,
                  32'hFF00_0004,3'd0,'0,'0,4'd1});

        // R11 reset in the middle of a pending lookup
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_2000; req_priv = 1'b1; req_write = 1'b0;
        cfg_xlate_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready == 1'b1, 11, "ready after mid-lookup reset", 32'(req_ready), 32'd1);
        chk(flt_vaddr == 32'd0, 11, "fault cleared by reset", flt_vaddr, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule